// File: doc/BRIEF.md
# Single-Slot Overwriting Signal Mailbox

This block passes events from a producer state machine to a consumer state machine that reacts at its own, unrelated pace. It holds one event together with its data word. The producer may post an event on any cycle and is never held off. When the consumer is ready to react, it looks for a pending event and takes it. If a new event arrives before the old one was taken, the old one is replaced. The slot therefore always carries the latest value, and a consumer that is slower than the producer sees only a subset of the events.

Two status outputs let the system judge whether the consumer keeps up. A sticky flag rises on the first lost event. A saturating counter records how many pending events were replaced before being read. Both clear only on reset. A signal that fans out to several consumers uses one instance per consumer, so each consumer has its own independent slot.

Both sides use valid/ready naming. On the write side `wr_ready` is tied high, so the producer is never back-pressured and every beat with `wr_valid` high is accepted. On the read side `rd_valid` means an event is pending. The consumer takes it by raising `rd_ready`, and the handshake completes in any cycle where both are high. `rd_ready` with nothing pending has no effect. Data is presented while `rd_valid` is high and stays stable until it is taken or replaced.

Top module: `sig_mailbox`

## Requirements
- R1: After reset `rd_valid` is 0, `overwrite_seen` is 0 and `lost_count` is 0.
- R2: `wr_ready` is always 1, and every write is accepted. A write to an empty slot makes `rd_valid` 1 on the next cycle, with `rd_data` equal to the written word.
- R3: A write while an event is pending and not being taken replaces it. From the next cycle `rd_data` shows the newer word and `rd_valid` stays 1.
- R4: A cycle with `rd_valid` and `rd_ready` both 1 consumes the event. With no write in that cycle, `rd_valid` is 0 on the next cycle. A pending event that is neither taken nor replaced keeps `rd_valid` 1 and `rd_data` stable.
- R5: When a write and a take occur in the same cycle, the consumer receives the old word in that cycle. The new word is pending on the next cycle, and this does not count as a loss.
- R6: `rd_ready` with `rd_valid` 0 changes no state: with no write, `rd_valid` stays 0 and the status outputs hold.
- R7: `overwrite_seen` goes to 1 in the cycle after the first replacement of a pending event (R3) and stays 1 until reset.
- R8: `lost_count` (CNT_W bits, default 8) increments by one per replacement of a pending event. It saturates at 2^CNT_W-1 and changes in no other case.
- R9: With a write every 2 cycles and a take attempt every 6 cycles, the consumer observes every third written event. With a take attempt every 2 cycles, it observes every event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Producer posts an event this cycle |
| wr_data | input | DATA_W | Data word carried by the event |
| wr_ready | output | 1 | Always 1; the producer never waits |
| rd_ready | input | 1 | Consumer takes the pending event |
| rd_valid | output | 1 | An event is pending |
| rd_data | output | DATA_W | Data of the pending event |
| overwrite_seen | output | 1 | Sticky flag: a pending event has been lost |
| lost_count | output | CNT_W | Saturating count of lost events |

## Verification
The checker checks these properties on every cycle:
- `wr_ready` is always 1.
- A write always leaves its own word pending on the next cycle, even when a take happens in the same cycle.
- A take with no write empties the slot.
- An idle slot stays empty when only `rd_ready` is raised.
- An untouched event holds its data.
- The loss flag never falls.
- The counter moves only on a replacement and never wraps past its maximum.

Some behaviour only the bench scenarios can show:
- The exact loss count under random traffic.
- Reaching and holding saturation.
- The old word being presented in a same-cycle write and take.
- The every-third-event pattern that appears when the consumer runs three times slower than the producer.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Slot operation decoded from the write and take strobes of a cycle
  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_FILL  = 2'd1,
    SLOT_DRAIN = 2'd2,
    SLOT_SWAP  = 2'd3
  } slot_op_e;

  function automatic slot_op_e decode_op(input logic wr, input logic take);
    slot_op_e op;
    unique case ({wr, take})
      2'b10:   op = SLOT_FILL;
      2'b01:   op = SLOT_DRAIN;
      2'b11:   op = SLOT_SWAP;
      default: op = SLOT_HOLD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_op_e          op,
  input  logic [DATA_W-1:0] din,
  output logic              full,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else begin
      unique case (op)
        SLOT_FILL, SLOT_SWAP: begin
          full <= 1'b1;
          dout <= din;
        end
        SLOT_DRAIN: full <= 1'b0;
        default:    full <= full;
      endcase
    end
  end

endmodule

// File: rtl/mbx_loss_tracker.sv
module mbx_loss_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lost,
  output logic             seen,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      count <= '0;
    end else if (lost) begin
      seen <= 1'b1;
      if (count != CNT_MAX) count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sig_mailbox.sv
module sig_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              overwrite_seen,
  output logic [CNT_W-1:0]  lost_count
);

  logic     full;
  logic     take;
  logic     lost;
  slot_op_e op;

  // The producer is never back-pressured
  assign wr_ready = 1'b1;
  assign take     = rd_ready & full;
  assign op       = decode_op(wr_valid, take);
  // A pending event is lost when a write lands and the consumer does not take it
  assign lost     = wr_valid & full & ~take;

  mbx_slot #(.DATA_W(DATA_W)) u_slot (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (op),
    .din  (wr_data),
    .full (full),
    .dout (rd_data)
  );

  mbx_loss_tracker #(.CNT_W(CNT_W)) u_loss (
    .clk  (clk),
    .rst_n(rst_n),
    .lost (lost),
    .seen (overwrite_seen),
    .count(lost_count)
  );

  assign rd_valid = full;

endmodule

// File: rtl/sig_mailbox_chk.sv
module sig_mailbox_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ready,
  input logic              rd_ready,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              overwrite_seen,
  input logic [CNT_W-1:0]  lost_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    if (rst_n) AST_WR_ALWAYS_READY: assert (wr_ready); // R2
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> rd_valid && rd_data == $past(wr_data)); // R3

  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !wr_valid |=> !rd_valid); // R4

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !wr_valid |=> rd_valid && $stable(rd_data)); // R4

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid && !wr_valid |=> !rd_valid && $stable(lost_count)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overwrite_seen |=> overwrite_seen); // R7

  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid && !rd_ready) |=> $stable(lost_count)); // R8

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    lost_count == CNT_MAX |=> lost_count == CNT_MAX); // R8

  AST_LOSS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && rd_valid && !rd_ready |=> overwrite_seen); // R7

endmodule

bind sig_mailbox sig_mailbox_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .wr_data       (wr_data),
  .wr_ready      (wr_ready),
  .rd_ready      (rd_ready),
  .rd_valid      (rd_valid),
  .rd_data       (rd_data),
  .overwrite_seen(overwrite_seen),
  .lost_count    (lost_count)
);

// File: tb/sig_mailbox_tb.sv
module sig_mailbox_tb;

  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_ready;
  logic              rd_ready = 1'b0;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              overwrite_seen;
  logic [CNT_W-1:0]  lost_count;

  sig_mailbox #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .overwrite_seen(overwrite_seen), .lost_count(lost_count)
  );

  always #10 clk = ~clk; // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit              m_pend;
  logic [DATA_W-1:0] m_data;
  bit              m_flag;
  logic [CNT_W-1:0]  m_cnt;
  bit              took;
  logic [DATA_W-1:0] took_data;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pend = 0; m_data = '0; m_flag = 0; m_cnt = '0;
  endtask

  // One cycle: drive at negedge, compare outputs against the model, advance model
  task automatic step(input bit wv, input logic [DATA_W-1:0] wd, input bit rr);
    bit take;
    @(negedge clk);
    wr_valid = wv; wr_data = wd; rd_ready = rr;
    #1;
    check("R2 wr_ready", {31'd0, wr_ready}, 32'd1);
    check("R4 rd_valid", {31'd0, rd_valid}, {31'd0, m_pend});
    if (m_pend) check("R3 rd_data", {16'd0, rd_data}, {16'd0, m_data});
    check("R7 overwrite_seen", {31'd0, overwrite_seen}, {31'd0, m_flag});
    check("R8 lost_count", {24'd0, lost_count}, {24'd0, m_cnt});
    take = rr && m_pend;
    took = take;
    took_data = rd_data;
    if (wv && m_pend && !take) begin
      m_flag = 1;
      m_cnt = sat_inc(m_cnt);
    end
    if (wv) begin
      m_pend = 1; m_data = wd;
    end else if (take) begin
      m_pend = 0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int last_k;
    int k;
    bit seq_ok;
    void'($urandom(32'd20240611));
    do_reset();
    #1;
    // R1 reset state
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1 overwrite_seen", {31'd0, overwrite_seen}, 32'd0);
    check("R1 lost_count", {24'd0, lost_count}, 32'd0);

    // R6 read on empty slot
    step(0, '0, 1);
    step(0, '0, 1);
    step(0, '0, 0);
    check("R6 empty read keeps slot empty", {31'd0, rd_valid}, 32'd0);
    check("R6 empty read keeps counter", {24'd0, lost_count}, 32'd0);

    // R2 write to empty slot
    step(1, 16'hA5A5, 0);
    step(0, '0, 0);
    check("R2 pending after write", {31'd0, rd_valid}, 32'd1);
    check("R2 data after write", {16'd0, rd_data}, 32'hA5A5);

    // R3/R7/R8 overwrite
    step(1, 16'h1234, 0);
    step(0, '0, 0);
    check("R3 newest value kept", {16'd0, rd_data}, 32'h1234);
    check("R7 flag set after overwrite", {31'd0, overwrite_seen}, 32'd1);
    check("R8 one loss counted", {24'd0, lost_count}, 32'd1);

    // R5 simultaneous write and take
    step(1, 16'hBEEF, 1);
    check("R5 reader gets old word", {16'd0, took_data}, 32'h1234);
    check("R5 take happened", {31'd0, took}, 32'd1);
    step(0, '0, 0);
    check("R5 new word pending", {16'd0, rd_data}, 32'hBEEF);
    check("R5 no loss counted", {24'd0, lost_count}, 32'd1);

    // R4 take empties
    step(0, '0, 1);
    step(0, '0, 0);
    check("R4 slot empty after take", {31'd0, rd_valid}, 32'd0);
    check("R7 flag stays set", {31'd0, overwrite_seen}, 32'd1);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 100) < 60, DATA_W'($urandom), ($urandom % 100) < 35);
    end

    // R8 saturation: many writes with no takes
    for (int i = 0; i < 300; i++) step(1, DATA_W'(i), 0);
    step(0, '0, 0);
    check("R8 counter saturated", {24'd0, lost_count}, {24'd0, CNT_MAX});
    step(1, 16'h0001, 0);
    step(0, '0, 0);
    check("R8 counter holds at max", {24'd0, lost_count}, {24'd0, CNT_MAX});

    // R9 slow consumer: write every 2 cycles, take every 6
    do_reset();
    last_k = -1; seq_ok = 1; k = 0;
    for (int t = 0; t < 60; t++) begin
      step((t % 2) == 0, DATA_W'(t / 2), (t % 6) == 5);
      if (took) begin
        if (last_k >= 0 && int'(took_data) != last_k + 3) seq_ok = 0;
        last_k = int'(took_data);
        k++;
      end
    end
    check("R9 slow consumer sees every third", {31'd0, seq_ok}, 32'd1);
    check("R9 slow consumer take count", k, 32'd10);

    // R9 fast consumer: take every 2 cycles
    do_reset();
    last_k = -1; seq_ok = 1; k = 0;
    for (int t = 0; t < 60; t++) begin
      step((t % 2) == 0, DATA_W'(t / 2), (t % 2) == 1);
      if (took) begin
        if (last_k >= 0 && int'(took_data) != last_k + 1) seq_ok = 0;
        last_k = int'(took_data);
        k++;
      end
    end
    check("R9 fast consumer sees every event", {31'd0, seq_ok}, 32'd1);
    check("R9 fast consumer take count", k, 32'd30);
    check("R9 fast consumer no loss", {24'd0, lost_count}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule